// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block takes a host write to the command/transfer-mode register and turns it into one or two requests on a card-side request/response interface. The 6-bit command index comes from bits 29:24 of the written word. If the block is not in application-command mode, the index is 18 or 25, and the auto-prefix bit (bit 3) is set, the block first sends a set-block-count command (index 23). The argument of that prefix command is the latched block count. Once the prefix is answered, the block sends the written command with the latched argument.

The card returns a length code with each response. The block packs a 4-byte or 16-byte response into four 32-bit response words. It then posts one-cycle event pulses and updates two level flags, space-available and data-available, according to the command index. When the card gives no response, the block applies fixed per-index fallback events. It also tracks whether the previous command was the application-command prefix (index 55). A command-inhibit flag covers the whole sequence, and a register write that arrives while the flag is high is dropped.

Top module: `sd_cmd_seq`

## Requirements
- R1: The index in written bits 29:24 and the latched argument are presented on `req_index_o`/`req_arg_o`. The request stays valid and stable until the cycle in which `req_ready_i` is high.
- R2: The prefix is sent when three conditions hold: the block is not in application mode, the index is 18 or 25, and written bit 3 is 1. The prefix request carries index 23 and the zero-extended `blk_count_i`. Its response updates no response word, event or flag, and the written command is requested after it.
- R3: No prefix is sent when written bit 3 is 0, when the index is anything other than 18 or 25, or while application mode is active.
- R4: Length code 1 (4 bytes) loads `rsp_data_i[127:96]` into word 0 and leaves words 1 to 3 unchanged.
- R5: Length code 2 (16 bytes) loads all four words from `rsp_data_i >> 8`, with word k = bits 32k+31:32k. Word 3 therefore holds the first three bytes in bits 23:0 and zero in bits 31:24.
- R6: Any response (code 1 or 2) raises the response event (`evt_o` bit 0). A 4-byte response to index 24 or 25 outside application mode also sets `space_avail_o` and the space event (bit 3).
- R7: After a response, outside application mode, index 12 clears `space_avail_o` and raises data-end (bit 1). For every other index, including any index while application mode is active, the block raises data-available (bit 2) and sets `data_avail_o` if `card_has_data_i` is 1; otherwise it raises data-end.
- R8: With no response (code 0 or 3) and outside application mode, index 52 or 5 raises timeout (bit 4) plus error (bit 5), and index 0 or 7 raises the response event. Any other index, or any index while application mode is active, raises nothing.
- R9: `app_mode_o` becomes 1 when an index-55 command completes and 0 when any other command completes.
- R10: `cmd_inhibit_o` rises in the cycle after an accepted write and falls in the cycle the events are posted. Writes made while it is high are ignored.
- R11: After reset, all response words, events, flags, `cmd_inhibit_o`, `app_mode_o` and `req_valid_o` are 0.
- R12: An accepted write clears `space_avail_o` and `data_avail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Write strobe for the command/transfer-mode register |
| cmd_wdata_i | input | 32 | Written word: index in 29:24, auto-prefix enable in bit 3 |
| arg_i | input | 32 | Command argument register value |
| blk_count_i | input | 16 | Block count field |
| req_valid_o | output | 1 | Card request valid |
| req_ready_i | input | 1 | Card request accepted |
| req_index_o | output | 6 | Requested command index |
| req_arg_o | output | 32 | Requested command argument |
| rsp_valid_i | input | 1 | Card response valid |
| rsp_len_i | input | 2 | 0 none, 1 four bytes, 2 sixteen bytes, 3 treated as none |
| rsp_data_i | input | 128 | Response bytes, first byte in bits 127:120 |
| card_has_data_i | input | 1 | Card has read data pending |
| resp0_o | output | 32 | Response word 0 |
| resp1_o | output | 32 | Response word 1 |
| resp2_o | output | 32 | Response word 2 |
| resp3_o | output | 32 | Response word 3 |
| evt_o | output | 6 | Event pulses: 0 response, 1 data-end, 2 data-available, 3 space, 4 timeout, 5 error |
| space_avail_o | output | 1 | Space-available flag |
| data_avail_o | output | 1 | Data-available flag |
| cmd_inhibit_o | output | 1 | Command in progress |
| app_mode_o | output | 1 | Application-command mode |

## Verification
The assertions assume the card raises `rsp_valid_i` only after it has accepted a request. They also assume the card never raises `req_ready_i` or `rsp_valid_i` outside a pending exchange. The bench acts as the card: it raises ready only while a request is valid, and returns exactly one response, one cycle after each accepted request. It drives register writes only at cycle boundaries. The one exception is a deliberate write made during a busy window, which checks that such a write is dropped.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_REQ, ST_PRE_WAIT, ST_MAIN_REQ, ST_MAIN_WAIT
  } seq_state_e;

  localparam int EV_W     = 6;
  localparam int EV_RESP  = 0;
  localparam int EV_DEND  = 1;
  localparam int EV_DAVL  = 2;
  localparam int EV_SPACE = 3;
  localparam int EV_TMO   = 4;
  localparam int EV_ERR   = 5;

  localparam logic [1:0] LEN_NONE  = 2'd0;
  localparam logic [1:0] LEN_SHORT = 2'd1;
  localparam logic [1:0] LEN_LONG  = 2'd2;

  localparam int IX_GO_IDLE   = 0;
  localparam int IX_IO_COND   = 5;
  localparam int IX_SELECT    = 7;
  localparam int IX_STOP      = 12;
  localparam int IX_RD_MULTI  = 18;
  localparam int IX_SET_COUNT = 23;
  localparam int IX_WR_SINGLE = 24;
  localparam int IX_WR_MULTI  = 25;
  localparam int IX_IO_DIRECT = 52;
  localparam int IX_APP_PFX   = 55;
endpackage

// File: rtl/sdcs_decode.sv
module sdcs_decode
  import sdcs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             app_i,
  input  logic             pre_en_i,
  output logic             need_pre_o,
  output logic             is_stop_o,
  output logic             is_write_o,
  output logic             fb_timeout_o,
  output logic             fb_resp_o,
  output logic             is_app_pfx_o
);
  function automatic logic hit(input logic [IDX_W-1:0] v, input int c);
    return v == IDX_W'(c);
  endfunction

  always_comb begin
    need_pre_o   = !app_i && pre_en_i && (hit(idx_i, IX_RD_MULTI) || hit(idx_i, IX_WR_MULTI));
    is_stop_o    = !app_i && hit(idx_i, IX_STOP);
    is_write_o   = !app_i && (hit(idx_i, IX_WR_SINGLE) || hit(idx_i, IX_WR_MULTI));
    fb_timeout_o = !app_i && (hit(idx_i, IX_IO_DIRECT) || hit(idx_i, IX_IO_COND));
    fb_resp_o    = !app_i && (hit(idx_i, IX_GO_IDLE) || hit(idx_i, IX_SELECT));
    is_app_pfx_o = hit(idx_i, IX_APP_PFX);
  end
endmodule

// File: rtl/sdcs_event_gen.sv
module sdcs_event_gen
  import sdcs_pkg::*;
(
  input  logic [1:0]      len_i,
  input  logic            has_data_i,
  input  logic            is_stop_i,
  input  logic            is_write_i,
  input  logic            fb_timeout_i,
  input  logic            fb_resp_i,
  output logic [EV_W-1:0] ev_o,
  output logic            set_space_o,
  output logic            clr_space_o,
  output logic            set_dav_o
);
  logic has_rsp;
  assign has_rsp = (len_i == LEN_SHORT) || (len_i == LEN_LONG);

  always_comb begin
    ev_o        = '0;
    set_space_o = 1'b0;
    clr_space_o = 1'b0;
    set_dav_o   = 1'b0;
    if (has_rsp) begin
      ev_o[EV_RESP] = 1'b1;
      if (len_i == LEN_SHORT && is_write_i) begin
        set_space_o    = 1'b1;
        ev_o[EV_SPACE] = 1'b1;
      end
      if (is_stop_i) begin
        clr_space_o   = 1'b1;
        ev_o[EV_DEND] = 1'b1;
      end else if (has_data_i) begin
        set_dav_o     = 1'b1;
        ev_o[EV_DAVL] = 1'b1;
      end else begin
        ev_o[EV_DEND] = 1'b1;
      end
    end else begin
      if (fb_timeout_i) begin
        ev_o[EV_TMO] = 1'b1;
        ev_o[EV_ERR] = 1'b1;
      end
      if (fb_resp_i) ev_o[EV_RESP] = 1'b1;
    end
  end
endmodule

// File: rtl/sdcs_resp_pack.sv
module sdcs_resp_pack
  import sdcs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RSP_W  = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [1:0]          len_i,
  input  logic [RSP_W-1:0]    data_i,
  output logic [RSP_W-1:0]    words_o
);
  localparam int NW = RSP_W / WORD_W;

  logic [RSP_W-1:0] shifted;
  assign shifted = data_i >> 8;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (load_i && len_i == LEN_LONG) begin
        q <= shifted[w*WORD_W +: WORD_W];
      end else if (load_i && len_i == LEN_SHORT && w == 0) begin
        q <= data_i[RSP_W-1 -: WORD_W];
      end
    end
    assign words_o[w*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/sdcs_seq_ctrl.sv
module sdcs_seq_ctrl
  import sdcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic need_pre_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output logic req_valid_o,
  output logic pre_phase_o,
  output logic busy_o,
  output logic accept_o,
  output logic finish_o
);
  seq_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i)     state_d = need_pre_i ? ST_PRE_REQ : ST_MAIN_REQ;
      ST_PRE_REQ:   if (req_ready_i) state_d = ST_PRE_WAIT;
      ST_PRE_WAIT:  if (rsp_valid_i) state_d = ST_MAIN_REQ;
      ST_MAIN_REQ:  if (req_ready_i) state_d = ST_MAIN_WAIT;
      ST_MAIN_WAIT: if (rsp_valid_i) state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  assign req_valid_o = (state_q == ST_PRE_REQ) || (state_q == ST_MAIN_REQ);
  assign pre_phase_o = (state_q == ST_PRE_REQ) || (state_q == ST_PRE_WAIT);
  assign busy_o      = state_q != ST_IDLE;
  assign accept_o    = start_i && (state_q == ST_IDLE);
  assign finish_o    = (state_q == ST_MAIN_WAIT) && rsp_valid_i;
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sdcs_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int IDX_LSB  = 24,
  parameter int PRE_BIT  = 3,
  parameter int REG_W    = 32,
  parameter int ARG_W    = 32,
  parameter int BLK_W    = 16,
  parameter int WORD_W   = 32,
  parameter int RSP_W    = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [REG_W-1:0]  cmd_wdata_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic [BLK_W-1:0]  blk_count_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [IDX_W-1:0]  req_index_o,
  output logic [ARG_W-1:0]  req_arg_o,
  input  logic              rsp_valid_i,
  input  logic [1:0]        rsp_len_i,
  input  logic [RSP_W-1:0]  rsp_data_i,
  input  logic              card_has_data_i,
  output logic [WORD_W-1:0] resp0_o,
  output logic [WORD_W-1:0] resp1_o,
  output logic [WORD_W-1:0] resp2_o,
  output logic [WORD_W-1:0] resp3_o,
  output logic [EV_W-1:0]   evt_o,
  output logic              space_avail_o,
  output logic              data_avail_o,
  output logic              cmd_inhibit_o,
  output logic              app_mode_o
);
  localparam int NW = RSP_W / WORD_W;

  logic [IDX_W-1:0] idx_q, idx_sel;
  logic             pre_en_q, pre_en_sel;
  logic [ARG_W-1:0] arg_q;
  logic [BLK_W-1:0] blk_q;
  logic             app_q, space_q, dav_q;
  logic [EV_W-1:0]  evt_q;

  logic busy, accept, finish, pre_phase;
  logic need_pre, is_stop, is_write, fb_timeout, fb_resp, is_app_pfx;
  logic [EV_W-1:0] ev_d;
  logic set_space, clr_space, set_dav;
  logic [RSP_W-1:0] words;
  logic unused_wdata;

  assign unused_wdata = ^cmd_wdata_i;

  // While idle the decoder looks at the incoming word; afterwards at the latch
  assign idx_sel    = busy ? idx_q    : cmd_wdata_i[IDX_LSB +: IDX_W];
  assign pre_en_sel = busy ? pre_en_q : cmd_wdata_i[PRE_BIT];

  sdcs_decode #(.IDX_W(IDX_W)) u_dec (
    .idx_i        (idx_sel),
    .app_i        (app_q),
    .pre_en_i     (pre_en_sel),
    .need_pre_o   (need_pre),
    .is_stop_o    (is_stop),
    .is_write_o   (is_write),
    .fb_timeout_o (fb_timeout),
    .fb_resp_o    (fb_resp),
    .is_app_pfx_o (is_app_pfx)
  );

  sdcs_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cmd_wr_i),
    .need_pre_i  (need_pre),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .req_valid_o (req_valid_o),
    .pre_phase_o (pre_phase),
    .busy_o      (busy),
    .accept_o    (accept),
    .finish_o    (finish)
  );

  sdcs_event_gen u_evt (
    .len_i        (rsp_len_i),
    .has_data_i   (card_has_data_i),
    .is_stop_i    (is_stop),
    .is_write_i   (is_write),
    .fb_timeout_i (fb_timeout),
    .fb_resp_i    (fb_resp),
    .ev_o         (ev_d),
    .set_space_o  (set_space),
    .clr_space_o  (clr_space),
    .set_dav_o    (set_dav)
  );

  sdcs_resp_pack #(.WORD_W(WORD_W), .RSP_W(RSP_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (finish),
    .len_i   (rsp_len_i),
    .data_i  (rsp_data_i),
    .words_o (words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      pre_en_q <= 1'b0;
      arg_q    <= '0;
      blk_q    <= '0;
    end else if (accept) begin
      idx_q    <= cmd_wdata_i[IDX_LSB +: IDX_W];
      pre_en_q <= cmd_wdata_i[PRE_BIT];
      arg_q    <= arg_i;
      blk_q    <= blk_count_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q   <= 1'b0;
      space_q <= 1'b0;
      dav_q   <= 1'b0;
      evt_q   <= '0;
    end else begin
      evt_q <= '0;
      if (accept) begin
        space_q <= 1'b0;
        dav_q   <= 1'b0;
      end else if (finish) begin
        evt_q   <= ev_d;
        app_q   <= is_app_pfx;
        space_q <= (space_q & ~clr_space) | set_space;
        dav_q   <= dav_q | set_dav;
      end
    end
  end

  assign req_index_o   = pre_phase ? IDX_W'(IX_SET_COUNT) : idx_q;
  assign req_arg_o     = pre_phase ? ARG_W'(blk_q) : arg_q;
  assign resp0_o       = words[0*WORD_W +: WORD_W];
  assign resp1_o       = words[1*WORD_W +: WORD_W];
  assign resp2_o       = words[2*WORD_W +: WORD_W];
  assign resp3_o       = words[(NW-1)*WORD_W +: WORD_W];
  assign evt_o         = evt_q;
  assign space_avail_o = space_q;
  assign data_avail_o  = dav_q;
  assign cmd_inhibit_o = busy;
  assign app_mode_o    = app_q;
endmodule

// File: rtl/sd_cmd_seq_chk.sv
module sd_cmd_seq_chk
  import sdcs_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_wr_i,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [IDX_W-1:0] req_index_o,
  input logic [ARG_W-1:0] req_arg_o,
  input logic [EV_W-1:0]  evt_o,
  input logic             space_avail_o,
  input logic             cmd_inhibit_o,
  input logic             app_mode_o
);
  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_index_o) && $stable(req_arg_o));

  a_r1_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> cmd_inhibit_o);

  a_r10_inhibit_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !cmd_inhibit_o |=> cmd_inhibit_o);

  a_r10_evt_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |-> $fell(cmd_inhibit_o));

  a_r8_timeout_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_TMO] |-> evt_o[EV_ERR]);

  a_r7_end_or_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o[EV_DEND] && evt_o[EV_DAVL]));

  a_r6_space_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_SPACE] |-> space_avail_o);

  a_r9_app_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(app_mode_o) |-> $fell(cmd_inhibit_o));
endmodule

bind sd_cmd_seq sd_cmd_seq_chk #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_wr_i      (cmd_wr_i),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_index_o   (req_index_o),
  .req_arg_o     (req_arg_o),
  .evt_o         (evt_o),
  .space_avail_o (space_avail_o),
  .cmd_inhibit_o (cmd_inhibit_o),
  .app_mode_o    (app_mode_o)
);

// File: tb/tb_sd_cmd_seq.sv
`timescale 1ns/1ps
module tb_sd_cmd_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [31:0]  cmd_wdata = '0;
  logic [31:0]  arg = '0;
  logic [15:0]  blk = '0;
  logic         req_valid, req_ready = 1'b0;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         rsp_valid = 1'b0;
  logic [1:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic         has_data = 1'b0;
  logic [31:0]  r0, r1, r2, r3;
  logic [5:0]   evt;
  logic         space, dav, inhibit, app;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sd_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .arg_i(arg), .blk_count_i(blk), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_index_o(req_index), .req_arg_o(req_arg), .rsp_valid_i(rsp_valid),
    .rsp_len_i(rsp_len), .rsp_data_i(rsp_data), .card_has_data_i(has_data),
    .resp0_o(r0), .resp1_o(r1), .resp2_o(r2), .resp3_o(r3), .evt_o(evt),
    .space_avail_o(space), .data_avail_o(dav), .cmd_inhibit_o(inhibit), .app_mode_o(app)
  );

  typedef struct {
    logic [31:0] w [4];
    logic [5:0]  ev;
    bit          sp, dv, ap;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] m_w [4];
  bit          m_app = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the completion image when inhibit drops
  bit prev_inh = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_inh && !inhibit) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({r3, r2, r1, r0} == {e.w[3], e.w[2], e.w[1], e.w[0]},
              {e.tag, " words"}, {r3, r2, r1, r0}, {e.w[3], e.w[2], e.w[1], e.w[0]});
          chk(evt == e.ev, {e.tag, " events"}, evt, e.ev);
          chk({space, dav, app} == {e.sp, e.dv, e.ap}, {e.tag, " flags sp/dav/app"},
              {space, dav, app}, {e.sp, e.dv, e.ap});
        end
      end else if (evt != 0) begin
        chk(1'b0, "R2 event outside completion", evt, 0);
      end
      prev_inh = inhibit;
    end
  end

  task automatic serve(input logic [5:0] idx, input logic [31:0] a, input logic [1:0] len,
                       input logic [127:0] data, input bit hd, input string tag);
    int n = 0;
    while (!req_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req_valid && req_index == idx && req_arg == a, {tag, " request"},
        {req_valid, req_index, req_arg}, {1'b1, idx, a});
    @(negedge clk);
    chk(req_valid && req_index == idx, {tag, " R1 held"}, {req_valid, req_index}, {1'b1, idx});
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1;
    rsp_len   = len;
    rsp_data  = data;
    has_data  = hd;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_data  = '0;
  endtask

  task automatic issue(input string tag, input logic [5:0] idx, input bit pre,
                       input logic [31:0] a, input logic [15:0] bc, input logic [1:0] len,
                       input logic [127:0] data, input bit hd, input bit extra_wr);
    exp_t e;
    logic [127:0] sh;
    bit need_pre;
    need_pre = !m_app && (idx == 6'd18 || idx == 6'd25) && pre;
    e.w = m_w;
    e.ev = '0;
    e.sp = 1'b0;
    e.dv = 1'b0;
    e.tag = tag;
    if (len == 2'd1 || len == 2'd2) begin
      if (len == 2'd1) begin
        e.w[0] = data[127:96];
      end else begin
        sh = data >> 8;
        for (int k = 0; k < 4; k++) e.w[k] = sh[32*k +: 32];
      end
      e.ev[0] = 1'b1;
      if (len == 2'd1 && !m_app && (idx == 6'd24 || idx == 6'd25)) begin
        e.sp = 1'b1;
        e.ev[3] = 1'b1;
      end
      if (!m_app && idx == 6'd12) begin
        e.sp = 1'b0;
        e.ev[1] = 1'b1;
      end else if (hd) begin
        e.dv = 1'b1;
        e.ev[2] = 1'b1;
      end else begin
        e.ev[1] = 1'b1;
      end
    end else if (!m_app) begin
      if (idx == 6'd52 || idx == 6'd5) e.ev[5:4] = 2'b11;
      if (idx == 6'd0 || idx == 6'd7) e.ev[0] = 1'b1;
    end
    e.ap = (idx == 6'd55);
    m_w = e.w;
    m_app = e.ap;
    exp_q.push_back(e);

    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = ({26'd0, idx} << 24) | (32'(pre) << 3);
    arg = a;
    blk = bc;
    @(negedge clk);
    chk(inhibit == 1'b1, {tag, " R10 inhibit after write"}, inhibit, 1);
    if (extra_wr) begin
      cmd_wdata = 32'h3F00_0008;
      arg = 32'hDEAD_BEEF;
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    if (need_pre) serve(6'd23, {16'd0, bc}, 2'd1, {4{32'hA5A5_5A5A}}, 1'b0, {tag, " R2 prefix"});
    serve(idx, a, len, data, hd, tag);
    @(negedge clk);
    if (extra_wr)
      chk(!req_valid && !inhibit, {tag, " R10 busy write dropped"}, {req_valid, inhibit}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_w[k] = '0;
    repeat (3) @(negedge clk);
    chk({r3, r2, r1, r0, evt, space, dav, inhibit, app, req_valid} == '0, "R11 reset state",
        {r3, r2, r1, r0, evt, space, dav, inhibit, app, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    issue("R8 idx0 no rsp",      6'd0,  0, 32'h0,        16'd0, 2'd0, '0, 0, 0);
    issue("R8 idx52 no rsp",     6'd52, 0, 32'h1234,     16'd0, 2'd0, '0, 0, 0);
    issue("R4 R7 idx8 short",    6'd8,  0, 32'h1AA,      16'd0, 2'd1,
          128'h11223344_55667788_99AABBCC_DDEEFF00, 0, 0);
    issue("R5 idx2 long",        6'd2,  0, 32'h0,        16'd0, 2'd2,
          128'h0102030405060708090A0B0C0D0E0F10, 0, 0);
    issue("R6 idx24 short",      6'd24, 0, 32'h200,      16'd0, 2'd1, {4{32'hCAFE0900}}, 0, 0);
    issue("R7 R12 idx12 stop",   6'd12, 0, 32'h0,        16'd0, 2'd1, {4{32'h00000B00}}, 1, 0);
    issue("R7 idx17 has data",   6'd17, 0, 32'h400,      16'd0, 2'd1, {4{32'h00000900}}, 1, 0);
    issue("R2 idx18 prefixed",   6'd18, 1, 32'h800,      16'd5, 2'd1, {4{32'h00000A00}}, 1, 0);
    issue("R2 R10 idx25 prefix", 6'd25, 1, 32'hC00,      16'hFFFF, 2'd1, {4{32'h00000C00}}, 0, 1);
    issue("R9 idx55 sets app",   6'd55, 0, 32'h10000,    16'd0, 2'd1, {4{32'h00000120}}, 0, 0);
    issue("R3 idx25 in app",     6'd25, 1, 32'hC04,      16'd3, 2'd1, {4{32'h00000D00}}, 0, 0);
    issue("R3 idx18 no pre bit", 6'd18, 0, 32'hC08,      16'd7, 2'd1, {4{32'h00000E00}}, 0, 0);
    issue("R9 idx55 no rsp",     6'd55, 0, 32'h0,        16'd0, 2'd0, '0, 0, 0);
    issue("R8 idx5 in app",      6'd5,  0, 32'h0,        16'd0, 2'd0, '0, 0, 0);
    issue("R8 idx9 no rsp",      6'd9,  0, 32'h0,        16'd0, 2'd0, '0, 0, 0);
    issue("R8 idx7 no rsp",      6'd7,  0, 32'h0,        16'd0, 2'd3, '0, 0, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule